// File: doc/BRIEF.md
# Line Interface Control Outputs with Hold Timer

This block drives the control lines of two subscriber line interface circuits from two internal 8-bit control registers. Each channel has a three-bit operating-mode code and a one-bit detector-select line. Together these four lines form the control code that picks which line event the interface circuit reports. The mode code follows its register bits on the next clock edge. The detector-select line follows its register bit only after a hold delay.

The hold delay is counted in clock cycles. Its length comes from a clock-frequency parameter: about 20 µs in normal operation and about 200 ns when the active-low power-down input `pwr_on` is low. Every output stays driven and keeps following its register during power-down. A register write port (address, 8-bit data, strobe) loads the registers. Channel 1 sits at address 6 and channel 2 at address 13.

Top module: `slic_line_ctrl`

## Requirements
- R1: After reset every `mode_sel` field and every `det_sel` bit is 0, and no hold delay is running.
- R2: A write to address 6 (channel 1, index 0) or address 13 (channel 2, index 1) sets that channel's `mode_sel` to data bits 7:5 (bit 7 is the code MSB). The new value is visible just after the clock edge that captures the write.
- R3: With `pwr_on` high, `det_sel` of the written channel takes data bit 2 exactly LONG edges after the write edge. LONG = ceil(CLK_HZ × 20 µs); it is 2000 at 100 MHz.
- R4: With `pwr_on` low at the write edge, `det_sel` takes data bit 2 exactly SHORT edges after the write edge. SHORT = ceil(CLK_HZ × 200 ns); it is 20 at 100 MHz.
- R5: A new write to the same channel before its delay ends restarts that delay. When the delay ends, `det_sel` takes the most recently written bit 2.
- R6: If `pwr_on` is first sampled low at edge j while a long delay has more than SHORT edges left, `det_sel` updates at edge j+SHORT.
- R7: `mode_sel` and `det_sel` keep following register writes while `pwr_on` is low.
- R8: Writes to any other address change no output and do not restart a running delay. A write to one channel leaves the other channel's outputs and delay untouched.
- R9: Data bits 4, 3, 1 and 0 are stored but have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of frequency CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_on | input | 1 | High for normal operation, low for power-down |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| mode_sel | output | 2×3 | Per-channel operating-mode code, index 0 = channel 1 |
| det_sel | output | 2 | Per-channel detector-select line, index 0 = channel 1 |

## Verification
The bench samples `det_sel` one edge before and exactly at the expected update edge. A delay that is off by one, or a count that starts at the wrong edge, therefore shows up as a wrong value at one of the two samples. Three writes that overlap inside one delay window catch a design that does not restart the timer, or that latches the bit value from the first write. Dropping `pwr_on` in the middle of a long hold catches a design that ignores power-down until the full 20 µs has passed. Writes to other addresses in the middle of a hold, and a write of the unused bits alone, expose a decoder that restarts a timer or lets those bits leak into the outputs.

// File: rtl/slic_ctl_pkg.sv
package slic_ctl_pkg;
    localparam int NUM_CH   = 2;
    localparam int REG_W    = 8;
    localparam int MODE_W   = 3;
    localparam int MODE_LSB = 5;
    localparam int DET_BIT  = 2;

    // Convert a delay in ns to whole clock cycles, rounding up, never below 1.
    function automatic longint unsigned hold_cycles(longint unsigned hz, longint unsigned ns);
        longint unsigned c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 64'd1 : c;
    endfunction
endpackage

// File: rtl/slic_chan_reg.sv
module slic_chan_reg
    import slic_ctl_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int MY_ADDR = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    output logic                hit,
    output logic [MODE_W-1:0]   mode,
    output logic                det_req
);
    typedef struct packed {
        logic [REG_W-1:0] cr;
    } reg_state_t;

    reg_state_t s_d, s_q;

    assign hit = wr_en && (wr_addr == ADDR_W'(MY_ADDR));

    always_comb begin
        s_d = s_q;
        if (hit) s_d.cr = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mode    = s_q.cr[MODE_LSB +: MODE_W];
    assign det_req = s_q.cr[DET_BIT];

    // R2: mode code follows the written bits on the next edge
    p_mode_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(MY_ADDR)) |=> mode == $past(wr_data[MODE_LSB +: MODE_W]));
    // R9: every bit of the register is stored
    p_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> s_q.cr == $past(wr_data));
    // R8: foreign addresses leave the register alone
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(s_q.cr));
endmodule

// File: rtl/e0_hold_timer.sv
module e0_hold_timer #(
    parameter int unsigned LONG_CYC  = 410,
    parameter int unsigned SHORT_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    input  logic load,
    input  logic target,
    output logic det
);
    localparam int CNT_W = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYC);
    localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYC);
    localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             det;
    } tmr_state_t;

    tmr_state_t s_d, s_q;
    logic [CNT_W-1:0] dec;

    always_comb begin
        s_d = s_q;
        dec = s_q.cnt - ONE_V;
        if (load) begin
            s_d.cnt = pwr_on ? LONG_V : SHORT_V;
        end else if (s_q.cnt == ONE_V) begin
            s_d.det = target;
            s_d.cnt = '0;
        end else if (s_q.cnt != '0) begin
            s_d.cnt = (!pwr_on && dec > SHORT_V) ? SHORT_V : dec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign det = s_q.det;

    // R3: count never exceeds the long hold length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LONG_V);
    // R3: on expiry the line takes the stored register bit
    p_det_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == ONE_V && !load) |=> det == $past(target));
    // R5: the line only moves on expiry
    p_det_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != ONE_V || load) |=> $stable(det));
    // R6: power-down caps the remaining wait
    p_pd_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_on && !load && s_q.cnt > SHORT_V) |=> s_q.cnt <= SHORT_V);
endmodule

// File: rtl/slic_line_ctrl.sv
module slic_line_ctrl
    import slic_ctl_pkg::*;
#(
    parameter longint unsigned CLK_HZ        = 20_480_000,
    parameter longint unsigned HOLD_LONG_NS  = 20_000,
    parameter longint unsigned HOLD_SHORT_NS = 200,
    parameter int              ADDR_W        = 4,
    parameter int              ADDR_CH1      = 6,
    parameter int              ADDR_CH2      = 13
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            pwr_on,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [REG_W-1:0]                wr_data,
    output logic [NUM_CH-1:0][MODE_W-1:0]   mode_sel,
    output logic [NUM_CH-1:0]               det_sel
);
    localparam int unsigned LONG_CYC  = int'(hold_cycles(CLK_HZ, HOLD_LONG_NS));
    localparam int unsigned SHORT_CYC = int'(hold_cycles(CLK_HZ, HOLD_SHORT_NS));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int CH_ADDR = (g == 0) ? ADDR_CH1 : ADDR_CH2;
        logic hit;
        logic det_req;

        slic_chan_reg #(
            .ADDR_W  (ADDR_W),
            .MY_ADDR (CH_ADDR)
        ) i_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .hit     (hit),
            .mode    (mode_sel[g]),
            .det_req (det_req)
        );

        e0_hold_timer #(
            .LONG_CYC  (LONG_CYC),
            .SHORT_CYC (SHORT_CYC)
        ) i_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .pwr_on (pwr_on),
            .load   (hit),
            .target (det_req),
            .det    (det_sel[g])
        );
    end

    // R1: outputs are clear on the first cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (mode_sel == '0 && det_sel == '0));
endmodule

// File: tb/test_slic_line_ctrl.sv
module test_slic_line_ctrl;
    localparam longint unsigned HZ = 100_000_000;
    localparam int LONG  = int'(HZ / 50_000);      // 20 us
    localparam int SHORT = int'(HZ / 5_000_000);   // 200 ns

    logic clk = 0, rst_n = 0, pwr_on = 1, wr_en = 0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0][2:0] mode_sel;
    logic [1:0] det_sel;

    int cyc = 0, n_run = 0, n_fail = 0, k = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    slic_line_ctrl #(.CLK_HZ(HZ)) i_slic_line_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .mode_sel(mode_sel), .det_sel(det_sel));

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 0;
        k = cyc;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic t_reset();
        chk("R1 mode ch1", mode_sel[0], 0);
        chk("R1 mode ch2", mode_sel[1], 0);
        chk("R1 det", det_sel, 0);
    endtask

    task automatic t_mode();
        wr(4'd6, 8'hA0);
        chk("R2 mode ch1", mode_sel[0], 5);
        chk("R8 mode ch2 untouched", mode_sel[1], 0);
        wr(4'd13, 8'h60);
        chk("R2 mode ch2", mode_sel[1], 3);
        chk("R8 mode ch1 untouched", mode_sel[0], 5);
    endtask

    task automatic t_long();
        int k0;
        wr(4'd6, 8'hA4); k0 = k;
        wait_until(k0 + LONG - 1);
        chk("R3 det ch1 before hold end", det_sel[0], 0);
        wait_until(k0 + LONG);
        chk("R3 det ch1 at hold end", det_sel[0], 1);
        chk("R8 det ch2 untouched", det_sel[1], 0);
    endtask

    task automatic t_unused();
        int k0;
        wr(4'd13, 8'h1B); k0 = k;
        chk("R9 mode ch2 ignores low bits", mode_sel[1], 0);
        wr(4'd6, 8'hBF);
        chk("R9 mode ch1 ignores low bits", mode_sel[0], 5);
        wait_until(k0 + LONG + 3);
        chk("R9 det ch2 ignores low bits", det_sel[1], 0);
        chk("R9 det ch1 keeps bit 2", det_sel[0], 1);
    endtask

    task automatic t_pd();
        int k0;
        pwr_on = 0;
        wr(4'd13, 8'hE4); k0 = k;
        chk("R7 mode ch2 in power-down", mode_sel[1], 7);
        wait_until(k0 + SHORT - 1);
        chk("R4 det ch2 before short end", det_sel[1], 0);
        wait_until(k0 + SHORT);
        chk("R4 det ch2 at short end", det_sel[1], 1);
        chk("R7 det ch1 held in power-down", det_sel[0], 1);
        pwr_on = 1;
    endtask

    task automatic t_restart();
        int k1, k2, k3;
        wr(4'd6, 8'hA0); k1 = k;
        wait_until(k1 + 499);
        wr(4'd6, 8'hA4); k2 = k;
        wait_until(k2 + 499);
        wr(4'd6, 8'hA0); k3 = k;
        wait_until(k1 + LONG);
        chk("R5 no update at first hold end", det_sel[0], 1);
        wait_until(k2 + LONG);
        chk("R5 no update at second hold end", det_sel[0], 1);
        wait_until(k3 + LONG - 1);
        chk("R5 before restarted hold end", det_sel[0], 1);
        wait_until(k3 + LONG);
        chk("R5 latest value at hold end", det_sel[0], 0);
    endtask

    task automatic t_cut();
        int k0, j;
        wr(4'd6, 8'hA4); k0 = k;
        wait_until(k0 + 300);
        pwr_on = 0;
        j = cyc + 1;
        wait_until(j + SHORT - 1);
        chk("R6 before cut hold end", det_sel[0], 0);
        wait_until(j + SHORT);
        chk("R6 at cut hold end", det_sel[0], 1);
        pwr_on = 1;
    endtask

    task automatic t_other();
        int k0;
        wr(4'd6, 8'hA0); k0 = k;
        wait_until(k0 + 99);
        wr(4'd5, 8'hFF);
        wr(4'd14, 8'hFF);
        wr(4'd0, 8'hFF);
        chk("R8 mode ch1 after foreign writes", mode_sel[0], 5);
        chk("R8 mode ch2 after foreign writes", mode_sel[1], 7);
        wait_until(k0 + LONG - 1);
        chk("R8 det ch1 before hold end", det_sel[0], 1);
        wait_until(k0 + LONG);
        chk("R8 hold not restarted by foreign writes", det_sel[0], 0);
        chk("R8 det ch2 untouched", det_sel[1], 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_mode();
        t_long();
        t_unused();
        t_pd();
        t_restart();
        t_cut();
        t_other();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(10 * 100_000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule